// File: doc/BRIEF.md
# Relocatable Interrupt Vector Address Generator

This block works out the program-space address that the program counter loads when the processor takes an interrupt, a trap or a hardware reset. A 9-bit base register selects one 128-word page of the 16-bit program space. Each vector occupies a four-word slot in that page, so a 5-bit vector number picks one of 32 slots.

Software relocates the table by writing the base register. A reset, or a reset-vector request, loads the base register with all ones, which puts the table at FF80h. The reset vector itself is always fetched from FF80h, whatever the register holds.

Each fetch also carries a flag that tells whether the target word is on-chip. The top page (FF80h–FFFFh) is on-chip only in microcomputer mode. Every other address, and every address in microprocessor mode, is external.

Top module: `ivec_locator`

## Requirements
- R1: While `rst` is high at a clock edge, the base register becomes 1FFh, and `fetch_valid`, `fetch_addr` and `fetch_onchip` become 0, 0000h and 0.
- R2: A cycle with `take_vec` high and `hw_rst_req` low makes `fetch_valid` high for exactly the following cycle, with `fetch_addr` = {base[8:0], `vec_num`[4:0], 2'b00}.
- R3: A base write (`ptr_wr_en`) changes the base at the clock edge that ends the write cycle. A vector taken in the same cycle as the write uses the old base.
- R4: A cycle with `hw_rst_req` high gives, in the following cycle, `fetch_valid` high and `fetch_addr` = FF80h, whatever the base and `take_vec` are.
- R5: `hw_rst_req` reloads the base with 1FFh and wins over a base write in the same cycle, so later vectors come from page FF80h.
- R6: `fetch_onchip` is 1 only when the new fetch address lies in FF80h–FFFFh and `mp_mode` was 0 (microcomputer mode) in the strobe cycle. Otherwise it is 0.
- R7: In a cycle after which neither `take_vec` nor `hw_rst_req` was high, `fetch_valid` is 0 and `fetch_addr` and `fetch_onchip` keep their values. A base write alone changes none of the outputs.
- R8: Vector number 31 lands at the page base plus 7Ch, the last slot of the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ptr_wr_en | input | 1 | Base register write strobe |
| ptr_wr_data | input | 9 | New page base (address bits 15:7) |
| take_vec | input | 1 | Take an interrupt or trap vector |
| vec_num | input | 5 | Vector slot number |
| hw_rst_req | input | 1 | Request the hardware reset vector |
| mp_mode | input | 1 | 1 = microprocessor mode, 0 = microcomputer mode |
| fetch_addr | output | 16 | Vector fetch address |
| fetch_valid | output | 1 | One-cycle pulse marking a new fetch address |
| fetch_onchip | output | 1 | Fetch target is on-chip memory |

## Verification
Every result is registered once. The outputs for a strobe are therefore due in the cycle after the strobe, and a base write shows only in vectors taken from the next cycle onward. The bench drives each stimulus on a falling edge. It compares all three outputs on the following falling edge, one rising edge later, against a model that tracks the base and the held outputs. After every strobe, it spends one idle cycle checking that the pulse has dropped and the address is held.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    localparam int ADDR_W = 16;
    localparam int PAGE_W = 7;                 // 128-word page
    localparam int SLOT_W = 2;                 // four words per slot
    localparam int VNUM_W = PAGE_W - SLOT_W;
    localparam int PTR_W  = ADDR_W - PAGE_W;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [VNUM_W-1:0] vnum_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {REQ_NONE, REQ_VEC, REQ_RESET} req_kind_e;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic  onchip;
    } fetch_t;

    localparam ptr_t PTR_RESET = '1;

    function automatic addr_t slot_addr(ptr_t base, vnum_t num);
        return {base, num, {SLOT_W{1'b0}}};
    endfunction

    function automatic logic in_top_page(addr_t a);
        return &a[ADDR_W-1:PAGE_W];
    endfunction
endpackage

// File: rtl/ivec_ptr_reg.sv
module ivec_ptr_reg
    import ivec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  ptr_t wr_data,
    input  logic reload,
    output ptr_t ptr
);
    always_ff @(posedge clk) begin
        if (rst || reload) ptr <= PTR_RESET;
        else if (wr_en)    ptr <= wr_data;
    end

    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(reload) && !$past(rst)) |-> ptr == $past(wr_data));
    a_r5_reload_ones: assert property (@(posedge clk) disable iff (rst)
        $past(reload) |-> ptr == PTR_RESET);
endmodule

// File: rtl/ivec_req_decode.sv
module ivec_req_decode
    import ivec_pkg::*;
(
    input  logic      take,
    input  logic      hw_req,
    output req_kind_e kind
);
    always_comb begin
        if (hw_req)    kind = REQ_RESET;
        else if (take) kind = REQ_VEC;
        else           kind = REQ_NONE;
    end

    always_comb begin
        a_r4_reset_priority: assert (!hw_req || kind == REQ_RESET);
    end
endmodule

// File: rtl/ivec_fetch_stage.sv
module ivec_fetch_stage
    import ivec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  req_kind_e kind,
    input  ptr_t      ptr,
    input  vnum_t     vnum,
    input  logic      mp_mode,
    output fetch_t    fetch
);
    addr_t next_addr;

    always_comb begin
        case (kind)
            REQ_RESET: next_addr = slot_addr(PTR_RESET, '0);
            REQ_VEC:   next_addr = slot_addr(ptr, vnum);
            default:   next_addr = fetch.addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch <= '0;
        end else begin
            fetch.valid <= (kind != REQ_NONE);
            if (kind != REQ_NONE) begin
                fetch.addr   <= next_addr;
                fetch.onchip <= in_top_page(next_addr) && !mp_mode;
            end
        end
    end

    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        fetch.valid |-> fetch.addr[SLOT_W-1:0] == '0);
    a_r4_reset_addr: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind) == REQ_RESET) |-> (fetch.valid && fetch.addr == 16'hFF80));
    a_r6_onchip_region: assert property (@(posedge clk) disable iff (rst)
        fetch.onchip |-> in_top_page(fetch.addr));
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind) == REQ_NONE) |-> (!fetch.valid && $stable(fetch.addr) && $stable(fetch.onchip)));
endmodule

// File: rtl/ivec_locator.sv
module ivec_locator
    import ivec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_wr_en,
    input  logic [PTR_W-1:0]  ptr_wr_data,
    input  logic              take_vec,
    input  logic [VNUM_W-1:0] vec_num,
    input  logic              hw_rst_req,
    input  logic              mp_mode,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid,
    output logic              fetch_onchip
);
    ptr_t      base_q;
    req_kind_e kind;
    fetch_t    fetch;

    ivec_ptr_reg u_ptr (
        .clk(clk), .rst(rst), .wr_en(ptr_wr_en), .wr_data(ptr_wr_data),
        .reload(hw_rst_req), .ptr(base_q)
    );

    ivec_req_decode u_dec (.take(take_vec), .hw_req(hw_rst_req), .kind(kind));

    ivec_fetch_stage u_fetch (
        .clk(clk), .rst(rst), .kind(kind), .ptr(base_q), .vnum(vec_num),
        .mp_mode(mp_mode), .fetch(fetch)
    );

    assign fetch_addr   = fetch.addr;
    assign fetch_valid  = fetch.valid;
    assign fetch_onchip = fetch.onchip;

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> ($past(take_vec) || $past(hw_rst_req)));
endmodule

// File: tb/sim_ivec_locator.sv
module sim_ivec_locator;
    logic clk = 0;
    logic rst = 1;
    logic ptr_wr_en = 0;
    logic [8:0] ptr_wr_data = '0;
    logic take_vec = 0;
    logic [4:0] vec_num = '0;
    logic hw_rst_req = 0;
    logic mp_mode = 0;
    logic [15:0] fetch_addr;
    logic fetch_valid, fetch_onchip;

    int n_chk = 0, n_fail = 0;
    logic [8:0]  m_ptr = 9'h1FF;
    logic [15:0] m_addr = '0;
    logic        m_valid = 0, m_onchip = 0;

    always #5 clk = ~clk;

    ivec_locator u0 (
        .clk(clk), .rst(rst), .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
        .take_vec(take_vec), .vec_num(vec_num), .hw_rst_req(hw_rst_req),
        .mp_mode(mp_mode), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
        .fetch_onchip(fetch_onchip)
    );

    task automatic check(input string tag);
        n_chk++;
        if (fetch_addr !== m_addr || fetch_valid !== m_valid || fetch_onchip !== m_onchip) begin
            n_fail++;
            $display("FAIL %s: addr=%h valid=%b onchip=%b expected addr=%h valid=%b onchip=%b",
                     tag, fetch_addr, fetch_valid, fetch_onchip, m_addr, m_valid, m_onchip);
        end
    endtask

    // One cycle of stimulus, driven on a falling edge; outputs checked on the next one.
    task automatic step(input logic tk, input logic hw, input logic we, input logic [8:0] wd,
                        input logic [4:0] vn, input logic md, input string tag);
        take_vec = tk; hw_rst_req = hw; ptr_wr_en = we; ptr_wr_data = wd;
        vec_num = vn; mp_mode = md;
        m_valid = tk | hw;
        if (hw)      m_addr = 16'hFF80;
        else if (tk) m_addr = {m_ptr, vn, 2'b00};
        if (tk | hw) m_onchip = (&m_addr[15:7]) && !md;
        if (hw)      m_ptr = 9'h1FF;
        else if (we) m_ptr = wd;
        @(negedge clk);
        take_vec = 0; hw_rst_req = 0; ptr_wr_en = 0;
        check(tag);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [8:0] pages [7];
        pages = '{9'h1FF, 9'h000, 9'h001, 9'h0AA, 9'h155, 9'h1FE, 9'h100};
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 reset outputs");
        step(1, 0, 0, '0, 5'd0, 0, "R1 reset base FF80 on-chip");          // R1, R6
        step(0, 0, 0, '0, 5'd0, 0, "R7 idle after reset vector");

        for (int p = 0; p < 7; p++) begin
            step(0, 0, 1, pages[p], 5'd0, 0, "R7 write alone changes no output");
            for (int v = 0; v < 32; v++) begin
                for (int md = 0; md < 2; md++) begin
                    step(1, 0, 0, '0, v[4:0], md[0], (v == 31) ? "R8 last slot +7Ch" : "R2 R6 vector address");
                    step(0, 0, 0, '0, 5'd0, ~md[0], "R2 R7 pulse drops, outputs held");
                end
            end
        end

        // R3: write and take in the same cycle use the old base
        step(0, 0, 1, 9'h012, 5'd0, 0, "R3 set base");
        step(1, 0, 1, 9'h034, 5'd7, 0, "R3 same-cycle take uses old base");
        step(1, 0, 0, '0, 5'd7, 0, "R3 next take uses new base");
        step(1, 0, 1, 9'h1FF, 5'd2, 0, "R3 old base before move to top page");
        step(1, 0, 0, '0, 5'd2, 0, "R3 R6 new top-page base on-chip");

        // R4/R5: reset request after remapping
        step(0, 0, 1, 9'h0C3, 5'd0, 0, "R5 remap");
        step(0, 1, 0, '0, 5'd0, 1, "R4 reset request gives FF80 external");
        step(1, 0, 0, '0, 5'd3, 0, "R5 later vector from FF80 page");
        step(0, 0, 1, 9'h044, 5'd0, 0, "R5 remap again");
        step(1, 1, 0, '0, 5'd9, 0, "R4 reset request wins over take");
        step(0, 0, 1, 9'h077, 5'd0, 0, "R5 remap third");
        step(0, 1, 1, 9'h022, 5'd0, 0, "R5 reset request wins over write");
        step(1, 0, 0, '0, 5'd31, 1, "R5 R8 base stays 1FF, external");
        step(0, 0, 0, '0, 5'd0, 0, "R7 final hold");

        // R1: reset mid-run clears outputs and base
        rst = 1;
        @(negedge clk);
        rst = 0;
        m_ptr = 9'h1FF; m_addr = '0; m_valid = 0; m_onchip = 0;
        check("R1 reset mid-run");
        step(1, 0, 0, '0, 5'd1, 0, "R1 base back to 1FF");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule